// File: doc/BRIEF.md
# Scatter-Gather Descriptor DMA Engine

This block is the bus-master data mover of a disk device. Once the device's command logic has put it in the armed state and the host then starts the transfer, the engine reads a chain of 8-byte region descriptors from system memory. For each descriptor it waits for a modelled disk delay. It then cuts the region into memory bursts that never straddle a page, and it offers each burst on a single-beat request port together with the matching offset into the device's sector buffer.

A busy answer from memory is not held. The request is dropped and issued again after a fixed backoff. The engine counts the command's remaining bytes against the bursts it issues. It finishes with a one-cycle done pulse when the end-of-table descriptor uses up exactly the command. An abort, a burst that would overrun the command, or a table that ends with bytes still owed all produce a one-cycle error pulse and send the engine back to idle.

Top module: `prd_dma_engine`

## Requirements
- R1: After reset, `state_o` is 0 (idle) and `mem_req_o`, `done_o` and `err_o` are low.
- R2: Engine state encoding: 0 idle, 1 armed, 2 moving. `arm_i` moves idle to armed. In armed, `start_i` takes effect only while `xfer_phase_i` is high; otherwise the engine stays armed and issues no request.
- R3: An accepted start issues a descriptor read in the next cycle. The read goes to `table_base_i` with bits 1:0 cleared, with length 8, `mem_fetch_o`=1 and `mem_we_o`=0.
- R4: Descriptor layout on `mem_rdata_i`: bits 31:0 give the region address, bits 47:32 the byte count (0 means 65536), and bit 63 the end-of-table flag.
- R5: A burst's length is the smallest of three values: the bytes left in the descriptor, the page size, and the distance from the burst address to the next page boundary. Consecutive bursts cover the region in address order.
- R6: `mem_we_o` on bursts equals `to_mem_i` as sampled at start (1 = disk-to-memory, i.e. a memory write). `buf_off_o` equals the bytes the command has moved before that burst.
- R7: The first burst of a descriptor is requested exactly DISK_DELAY + (count/SECTOR_BYTES) + 3 cycles after the cycle in which the descriptor read completes.
- R8: A request answered with `mem_busy_i` is dropped (requests last one cycle). It is reissued unchanged exactly BACKOFF + 2 cycles after the rejected cycle.
- R9: The pointer advances by 8 when a descriptor read completes. When a descriptor without the end-of-table flag is used up, the next descriptor is read from that advanced pointer.
- R10: When an end-of-table descriptor is used up and no command bytes remain, `done_o` pulses for one cycle and the engine is idle in that cycle.
- R11: If a burst would exceed the remaining command bytes, no burst is issued. The same outcome applies if the table ends with bytes remaining: `err_o` pulses for one cycle and the engine goes idle.
- R12: `abort_i` in the armed or moving state gives a one-cycle `err_o` pulse in the next cycle and returns the engine to idle. In idle it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | Device ready for a DMA command; idle to armed |
| start_i | input | 1 | Host start of the transfer |
| xfer_phase_i | input | 1 | Device is in its DMA-transfer phase |
| abort_i | input | 1 | Cancel the transfer |
| table_base_i | input | 32 | Descriptor table base address |
| to_mem_i | input | 1 | 1: disk-to-memory, 0: memory-to-disk |
| cmd_bytes_i | input | 18 | Command byte count |
| mem_req_o | output | 1 | One-cycle memory request |
| mem_fetch_o | output | 1 | Request is a descriptor read |
| mem_we_o | output | 1 | Request writes memory |
| mem_addr_o | output | 32 | Request address |
| mem_len_o | output | 17 | Request length in bytes |
| buf_off_o | output | 18 | Sector-buffer byte offset of the burst |
| mem_busy_i | input | 1 | Memory rejects the current request |
| mem_done_i | input | 1 | Accepted request completed |
| mem_rdata_i | input | 64 | Descriptor data, valid with `mem_done_i` |
| state_o | output | 2 | Engine state |
| done_o | output | 1 | Transfer finished |
| err_o | output | 1 | Transfer ended in error |

## Verification
A request shows up one cycle after an accepted start, and a burst shows up two cycles after the previous burst completes. A descriptor's first burst follows its read completion by the disk delay plus the sector count plus three cycles, and a busy-rejected request comes back after the backoff plus two. Done and error are due in the cycle after the deciding edge. The memory responder in the bench stamps every request and completion with a cycle counter and compares these gaps exactly. All stimulus and all sampling happen on the falling edge, so every value read is one the rising edge has already settled.

// File: rtl/prd_pkg.sv
`timescale 1ns/1ps
package prd_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_ARMED = 2'd1,
    ENG_MOVE  = 2'd2
  } eng_state_t;

  typedef enum logic [1:0] {
    PH_WAIT    = 2'd0,
    PH_DELAY   = 2'd1,
    PH_ISSUE   = 2'd2,
    PH_BACKOFF = 2'd3
  } phase_t;

  localparam int DESC_W     = 64;
  localparam int DESC_BYTES = 8;
  localparam int CNT_LSB    = 32;
  localparam int CNT_BITS   = 16;
  localparam int EOT_BIT    = 63;
endpackage

// File: rtl/prd_desc_decode.sv
`timescale 1ns/1ps
module prd_desc_decode #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 17
) (
  input  logic [prd_pkg::DESC_W-1:0] raw,
  output logic [ADDR_W-1:0]          base,
  output logic [LEN_W-1:0]           count,
  output logic                       eot
);
  import prd_pkg::*;
  logic [CNT_BITS-1:0] cnt_field;
  logic                unused_rsvd;

  assign base        = raw[ADDR_W-1:0];
  assign cnt_field   = raw[CNT_LSB +: CNT_BITS];
  assign eot         = raw[EOT_BIT];
  // zero count encodes the largest region
  assign count       = (cnt_field == '0) ? LEN_W'(1 << CNT_BITS) : LEN_W'(cnt_field);
  assign unused_rsvd = ^raw[EOT_BIT-1:CNT_LSB+CNT_BITS];
endmodule

// File: rtl/prd_burst_calc.sv
`timescale 1ns/1ps
module prd_burst_calc #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 17,
  parameter int PAGE_BYTES = 4096
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  left,
  output logic [LEN_W-1:0]  len
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  logic [LEN_W-1:0] room;
  logic [LEN_W-1:0] capped;
  logic [ADDR_W-PAGE_W-1:0] unused_hi;

  assign room      = LEN_W'(PAGE_BYTES) - LEN_W'(addr[PAGE_W-1:0]);
  assign capped    = (left < LEN_W'(PAGE_BYTES)) ? left : LEN_W'(PAGE_BYTES);
  assign len       = (capped < room) ? capped : room;
  assign unused_hi = addr[ADDR_W-1:PAGE_W];
endmodule

// File: rtl/prd_wait_timer.sv
`timescale 1ns/1ps
module prd_wait_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/prd_dma_engine.sv
`timescale 1ns/1ps
module prd_dma_engine #(
  parameter int ADDR_W       = 32,
  parameter int CMD_W        = 18,
  parameter int PAGE_BYTES   = 4096,
  parameter int SECTOR_BYTES = 512,
  parameter int DISK_DELAY   = 20,
  parameter int BACKOFF      = 6,
  parameter int LEN_W        = prd_pkg::CNT_BITS + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm_i,
  input  logic              start_i,
  input  logic              xfer_phase_i,
  input  logic              abort_i,
  input  logic [ADDR_W-1:0] table_base_i,
  input  logic              to_mem_i,
  input  logic [CMD_W-1:0]  cmd_bytes_i,
  output logic              mem_req_o,
  output logic              mem_fetch_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [LEN_W-1:0]  mem_len_o,
  output logic [CMD_W-1:0]  buf_off_o,
  input  logic              mem_busy_i,
  input  logic              mem_done_i,
  input  logic [prd_pkg::DESC_W-1:0] mem_rdata_i,
  output logic [1:0]        state_o,
  output logic              done_o,
  output logic              err_o
);
  import prd_pkg::*;

  localparam int SEC_SH = $clog2(SECTOR_BYTES);
  localparam int TMR_W  = $clog2(DISK_DELAY + BACKOFF + (1 << CNT_BITS) / SECTOR_BYTES + 2);

  eng_state_t        eng;
  phase_t            ph;
  logic [ADDR_W-1:0] ptr, cur_addr, d_base, base_al;
  logic [LEN_W-1:0]  left, d_cnt, burst_len, d_sectors;
  logic              eot_r, d_eot, dir_r;
  logic [CMD_W-1:0]  remain, moved;
  logic              in_wait, busy_hit, fetch_done, burst_done;
  logic              tmr_load, tmr_zero;
  logic [TMR_W-1:0]  tmr_val;
  logic [1:0]        unused_base_lsb;

  prd_desc_decode #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dec (
    .raw(mem_rdata_i), .base(d_base), .count(d_cnt), .eot(d_eot));

  prd_burst_calc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)) u_split (
    .addr(cur_addr), .left(left), .len(burst_len));

  prd_wait_timer #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .val(tmr_val), .zero(tmr_zero));

  assign base_al         = {table_base_i[ADDR_W-1:2], 2'b00};
  assign unused_base_lsb = table_base_i[1:0];
  assign d_sectors       = d_cnt >> SEC_SH;

  assign in_wait    = (eng == ENG_MOVE) && (ph == PH_WAIT) && !abort_i;
  assign busy_hit   = in_wait && mem_req_o && mem_busy_i;
  assign fetch_done = in_wait && !mem_req_o && mem_done_i && mem_fetch_o;
  assign burst_done = in_wait && !mem_req_o && mem_done_i && !mem_fetch_o;
  assign tmr_load   = busy_hit || fetch_done;
  assign tmr_val    = busy_hit ? TMR_W'(BACKOFF)
                               : TMR_W'(DISK_DELAY) + TMR_W'(d_sectors);
  assign state_o    = eng;

  always_ff @(posedge clk) begin
    if (rst) begin
      eng         <= ENG_IDLE;
      ph          <= PH_WAIT;
      ptr         <= '0;
      cur_addr    <= '0;
      left        <= '0;
      eot_r       <= 1'b0;
      dir_r       <= 1'b0;
      remain      <= '0;
      moved       <= '0;
      mem_req_o   <= 1'b0;
      mem_fetch_o <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_len_o   <= '0;
      buf_off_o   <= '0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      mem_req_o <= 1'b0;
      done_o    <= 1'b0;
      err_o     <= 1'b0;
      if (abort_i && eng != ENG_IDLE) begin
        eng   <= ENG_IDLE;
        err_o <= 1'b1;
      end else begin
        unique case (eng)
          ENG_IDLE: if (arm_i) eng <= ENG_ARMED;
          ENG_ARMED: begin
            if (start_i && xfer_phase_i) begin
              eng         <= ENG_MOVE;
              ph          <= PH_WAIT;
              ptr         <= base_al;
              remain      <= cmd_bytes_i;
              moved       <= '0;
              dir_r       <= to_mem_i;
              mem_req_o   <= 1'b1;
              mem_fetch_o <= 1'b1;
              mem_we_o    <= 1'b0;
              mem_addr_o  <= base_al;
              mem_len_o   <= LEN_W'(DESC_BYTES);
            end
          end
          ENG_MOVE: begin
            unique case (ph)
              PH_WAIT: begin
                if (busy_hit) begin
                  ph <= PH_BACKOFF;
                end else if (fetch_done) begin
                  cur_addr <= d_base;
                  left     <= d_cnt;
                  eot_r    <= d_eot;
                  ptr      <= ptr + ADDR_W'(DESC_BYTES);
                  ph       <= PH_DELAY;
                end else if (burst_done) begin
                  cur_addr <= cur_addr + ADDR_W'(mem_len_o);
                  left     <= left - mem_len_o;
                  remain   <= remain - CMD_W'(mem_len_o);
                  moved    <= moved + CMD_W'(mem_len_o);
                  ph       <= PH_ISSUE;
                end
              end
              PH_DELAY: if (tmr_zero) ph <= PH_ISSUE;
              PH_BACKOFF: begin
                if (tmr_zero) begin
                  mem_req_o <= 1'b1;
                  ph        <= PH_WAIT;
                end
              end
              PH_ISSUE: begin
                if (left == '0) begin
                  if (eot_r) begin
                    eng <= ENG_IDLE;
                    if (remain == '0) done_o <= 1'b1;
                    else              err_o  <= 1'b1;
                  end else begin
                    mem_req_o   <= 1'b1;
                    mem_fetch_o <= 1'b1;
                    mem_we_o    <= 1'b0;
                    mem_addr_o  <= ptr;
                    mem_len_o   <= LEN_W'(DESC_BYTES);
                    ph          <= PH_WAIT;
                  end
                end else if (CMD_W'(burst_len) > remain) begin
                  eng   <= ENG_IDLE;
                  err_o <= 1'b1;
                end else begin
                  mem_req_o   <= 1'b1;
                  mem_fetch_o <= 1'b0;
                  mem_we_o    <= dir_r;
                  mem_addr_o  <= cur_addr;
                  mem_len_o   <= burst_len;
                  buf_off_o   <= moved;
                  ph          <= PH_WAIT;
                end
              end
              default: ph <= PH_WAIT;
            endcase
          end
          default: eng <= ENG_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/prd_dma_checker.sv
`timescale 1ns/1ps
module prd_dma_checker #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 17,
  parameter int PAGE_BYTES = 4096
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              xfer_phase_i,
  input logic              abort_i,
  input logic              mem_req_o,
  input logic              mem_fetch_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [LEN_W-1:0]  mem_len_o,
  input logic [1:0]        state_o,
  input logic              done_o,
  input logic              err_o
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);

  assert_armed_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd1 && !(start_i && xfer_phase_i) && !abort_i) |=> (state_o == 2'd1 && !mem_req_o));

  assert_start_fetch_R3: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd1 && start_i && xfer_phase_i && !abort_i) |=> (state_o == 2'd2 && mem_req_o && mem_fetch_o));

  assert_fetch_shape_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && mem_fetch_o) |-> (mem_len_o == LEN_W'(8) && !mem_we_o && mem_addr_o[1:0] == 2'b00));

  assert_burst_in_page_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_fetch_o) |-> (mem_len_o != '0 &&
      (32'(mem_addr_o[PAGE_W-1:0]) + 32'(mem_len_o)) <= 32'(PAGE_BYTES)));

  assert_req_single_R8: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |=> !mem_req_o);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (state_o == 2'd0 && !err_o));

  assert_err_idle_R11: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (state_o == 2'd0 && !mem_req_o));

  assert_abort_R12: assert property (@(posedge clk) disable iff (rst)
    (abort_i && state_o != 2'd0) |=> (state_o == 2'd0 && err_o));
endmodule

bind prd_dma_engine prd_dma_checker #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)
) u_prd_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .xfer_phase_i(xfer_phase_i),
  .abort_i(abort_i), .mem_req_o(mem_req_o), .mem_fetch_o(mem_fetch_o),
  .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_len_o(mem_len_o),
  .state_o(state_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/tb_prd_dma_engine.sv
`timescale 1ns/1ps
module tb_prd_dma_engine;
  localparam int PAGE = 4096, SECT = 512, DDLY = 20, BOFF = 6, LAT = 3;
  localparam int NC = 7, LOGN = 32;

  typedef struct packed {
    logic [31:0] tb;
    logic [31:0] a0;
    logic [15:0] c0;
    logic [31:0] a1;
    logic [15:0] c1;
    logic [1:0]  n;
    logic [17:0] cmd;
    logic        dir;
    logic [3:0]  busy;
  } case_t;

  localparam case_t CASES [NC] = '{
    '{tb:32'h100,  a0:32'h1000,  c0:16'd2048, a1:32'h0,    c1:16'd0,    n:2'd1, cmd:18'd2048,  dir:1'b1, busy:4'd0},
    '{tb:32'h200,  a0:32'h1C00,  c0:16'd2048, a1:32'h0,    c1:16'd0,    n:2'd1, cmd:18'd2048,  dir:1'b0, busy:4'd1},
    '{tb:32'h300,  a0:32'h3000,  c0:16'h2000, a1:32'h8E00, c1:16'd1024, n:2'd2, cmd:18'd9216,  dir:1'b1, busy:4'd2},
    '{tb:32'h400,  a0:32'h5000,  c0:16'd4096, a1:32'h0,    c1:16'd0,    n:2'd1, cmd:18'd2048,  dir:1'b1, busy:4'd0},
    '{tb:32'h500,  a0:32'h6000,  c0:16'd1024, a1:32'h0,    c1:16'd0,    n:2'd1, cmd:18'd2048,  dir:1'b0, busy:4'd0},
    '{tb:32'h4006, a0:32'h7000,  c0:16'd512,  a1:32'h0,    c1:16'd0,    n:2'd1, cmd:18'd512,   dir:1'b0, busy:4'd1},
    '{tb:32'h600,  a0:32'h10000, c0:16'd0,    a1:32'h0,    c1:16'd0,    n:2'd1, cmd:18'd65536, dir:1'b1, busy:4'd0}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic arm_i = 0, start_i = 0, xfer_phase_i = 0, abort_i = 0, to_mem_i = 0;
  logic [31:0] table_base_i = '0;
  logic [17:0] cmd_bytes_i = '0;
  logic mem_req_o, mem_fetch_o, mem_we_o, done_o, err_o;
  logic [31:0] mem_addr_o;
  logic [16:0] mem_len_o;
  logic [17:0] buf_off_o;
  logic mem_busy_i = 0, mem_done_i = 0;
  logic [63:0] mem_rdata_i = '0;
  logic [1:0] state_o;

  prd_dma_engine #(.PAGE_BYTES(PAGE), .SECTOR_BYTES(SECT), .DISK_DELAY(DDLY), .BACKOFF(BOFF)) dut (
    .clk(clk), .rst(rst), .arm_i(arm_i), .start_i(start_i), .xfer_phase_i(xfer_phase_i),
    .abort_i(abort_i), .table_base_i(table_base_i), .to_mem_i(to_mem_i), .cmd_bytes_i(cmd_bytes_i),
    .mem_req_o(mem_req_o), .mem_fetch_o(mem_fetch_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_len_o(mem_len_o), .buf_off_o(buf_off_o), .mem_busy_i(mem_busy_i), .mem_done_i(mem_done_i),
    .mem_rdata_i(mem_rdata_i), .state_o(state_o), .done_o(done_o), .err_o(err_o));

  always #4 clk = ~clk;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, bad = 0;
  bit finished = 0;
  case_t cur;
  int busy_left = 0, lat_cnt = 0;
  logic [63:0] rd_hold;
  bit pend_fetch;
  int t_fdone, t_breq, t_busy, t_retry;
  logic [31:0] lg_addr [LOGN];
  int lg_len [LOGN], lg_off [LOGN];
  bit lg_f [LOGN], lg_we [LOGN];
  int lg_n;
  logic [31:0] ex_addr [LOGN];
  int ex_len [LOGN], ex_off [LOGN];
  bit ex_f [LOGN], ex_we [LOGN];
  int ex_n;
  bit ex_err;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] desc_at(input logic [31:0] a);
    logic [31:0] tal = {cur.tb[31:2], 2'b00};
    if (a == tal) return {cur.n == 2'd1, 15'd0, cur.c0, cur.a0};
    if (cur.n == 2'd2 && a == tal + 32'd8) return {1'b1, 15'd0, cur.c1, cur.a1};
    return '0;
  endfunction

  task automatic add_exp(input logic [31:0] a, input int l, input bit f, input bit we, input int off);
    ex_addr[ex_n] = a; ex_len[ex_n] = l; ex_f[ex_n] = f; ex_we[ex_n] = we; ex_off[ex_n] = off;
    ex_n++;
  endtask

  task automatic build_exp();
    int rem = int'(cur.cmd), moved = 0;
    logic [31:0] ptr = {cur.tb[31:2], 2'b00};
    ex_n = 0; ex_err = 0;
    for (int d = 0; d < int'(cur.n); d++) begin
      logic [31:0] a = (d == 0) ? cur.a0 : cur.a1;
      int c = (d == 0) ? int'(cur.c0) : int'(cur.c1);
      int left = (c == 0) ? 65536 : c;
      add_exp(ptr, 8, 1'b1, 1'b0, 0);
      ptr = ptr + 32'd8;
      while (left > 0) begin
        int room = PAGE - int'(a % PAGE);
        int l = (left < PAGE) ? left : PAGE;
        if (room < l) l = room;
        if (l > rem) begin ex_err = 1; return; end
        add_exp(a, l, 1'b0, cur.dir, moved);
        a = a + 32'(l); left -= l; rem -= l; moved += l;
      end
    end
    if (rem != 0) ex_err = 1;
  endtask

  task responder();
    forever begin
      @(negedge clk);
      mem_busy_i = 0;
      mem_done_i = 0;
      if (lat_cnt > 0) begin
        lat_cnt--;
        if (lat_cnt == 0) begin
          mem_done_i = 1;
          mem_rdata_i = rd_hold;
          if (pend_fetch && t_fdone < 0) t_fdone = cyc;
        end
      end
      if (mem_req_o) begin
        if (!mem_fetch_o && t_breq < 0) t_breq = cyc;
        if (t_busy >= 0 && t_retry < 0 && cyc > t_busy) t_retry = cyc;
        if (busy_left > 0) begin
          busy_left--;
          mem_busy_i = 1;
          if (t_busy < 0) t_busy = cyc;
        end else begin
          if (lg_n < LOGN) begin
            lg_addr[lg_n] = mem_addr_o; lg_len[lg_n] = int'(mem_len_o);
            lg_f[lg_n] = mem_fetch_o; lg_we[lg_n] = mem_we_o; lg_off[lg_n] = int'(buf_off_o);
            lg_n++;
          end
          pend_fetch = mem_fetch_o;
          rd_hold = desc_at(mem_addr_o);
          lat_cnt = LAT;
        end
      end
    end
  endtask

  task automatic prep(input int i);
    cur = CASES[i];
    busy_left = int'(cur.busy);
    lg_n = 0;
    t_fdone = -1; t_breq = -1; t_busy = -1; t_retry = -1;
    build_exp();
  endtask

  task automatic arm_and_start();
    @(negedge clk) arm_i = 1;
    @(negedge clk) arm_i = 0;
    chk(state_o == 2'd1, "R2 armed after arm", state_o, 1);
    table_base_i = cur.tb; to_mem_i = cur.dir; cmd_bytes_i = cur.cmd;
    xfer_phase_i = 1; start_i = 1;
    @(negedge clk) start_i = 0; xfer_phase_i = 0;
    chk(state_o == 2'd2, "R3 moving after start", state_o, 2);
  endtask

  task automatic run_case(input int i);
    bit gd = 0, ge = 0;
    int sec0, nchk;
    prep(i);
    arm_and_start();
    for (int k = 0; k < 4000 && !(gd || ge); k++) begin
      @(negedge clk);
      gd = done_o; ge = err_o;
    end
    chk(gd == !ex_err && ge == ex_err, ex_err ? "R11 error outcome" : "R10 done outcome",
        {gd, ge}, {!ex_err, ex_err});
    chk(state_o == 2'd0, "R10 idle at end", state_o, 0);
    chk(lg_n == ex_n, "R5 request count", lg_n, ex_n);
    nchk = (lg_n < ex_n) ? lg_n : ex_n;
    for (int j = 0; j < nchk; j++) begin
      if (ex_f[j]) begin
        chk(lg_f[j] && lg_addr[j] == ex_addr[j] && lg_len[j] == 8 && !lg_we[j],
            (j == 0) ? "R3 descriptor read" : "R9 next descriptor read", lg_addr[j], ex_addr[j]);
      end else begin
        chk(!lg_f[j] && lg_addr[j] == ex_addr[j], "R5 burst address", lg_addr[j], ex_addr[j]);
        chk(lg_len[j] == ex_len[j], (cur.c0 == 0) ? "R4 zero count burst length" : "R5 burst length",
            lg_len[j], ex_len[j]);
        chk(lg_we[j] == ex_we[j] && lg_off[j] == ex_off[j], "R6 direction and buffer offset",
            {lg_we[j], 32'(lg_off[j])}, {ex_we[j], 32'(ex_off[j])});
      end
    end
    if (t_breq >= 0) begin
      sec0 = ((cur.c0 == 0) ? 65536 : int'(cur.c0)) / SECT;
      chk(t_breq - t_fdone == DDLY + sec0 + 3, "R7 disk delay", t_breq - t_fdone, DDLY + sec0 + 3);
    end
    if (cur.busy != 0)
      chk(t_retry - t_busy == BOFF + 2, "R8 backoff reissue", t_retry - t_busy, BOFF + 2);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    fork responder(); join_none
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset values
    chk(state_o == 2'd0 && !mem_req_o && !done_o && !err_o, "R1 reset state",
        {state_o, mem_req_o, done_o, err_o}, 0);

    // R2: start without the transfer phase is ignored
    @(negedge clk) arm_i = 1;
    @(negedge clk) arm_i = 0;
    chk(state_o == 2'd1, "R2 arm", state_o, 1);
    start_i = 1; xfer_phase_i = 0;
    @(negedge clk) start_i = 0;
    chk(state_o == 2'd1 && !mem_req_o, "R2 start outside transfer phase", {state_o, mem_req_o}, 2);

    // R12: abort from armed, then abort in idle
    abort_i = 1;
    @(negedge clk) abort_i = 0;
    chk(err_o && state_o == 2'd0, "R12 abort in armed", {err_o, state_o}, 4);
    abort_i = 1;
    @(negedge clk) abort_i = 0;
    chk(!err_o && state_o == 2'd0, "R12 abort in idle ignored", {err_o, state_o}, 0);
    @(negedge clk);
    chk(!err_o && state_o == 2'd0, "R12 idle stays idle", {err_o, state_o}, 0);

    for (int i = 0; i < NC; i++) run_case(i);

    // R12: abort while moving, during the disk delay
    prep(0);
    arm_and_start();
    for (int k = 0; k < 100 && t_fdone < 0; k++) @(negedge clk);
    repeat (3) @(negedge clk);
    abort_i = 1;
    @(negedge clk) abort_i = 0;
    chk(err_o && state_o == 2'd0, "R12 abort while moving", {err_o, state_o}, 4);
    repeat (40) @(negedge clk);
    chk(state_o == 2'd0 && lg_n == 1, "R12 no burst after abort", lg_n, 1);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule